// File: doc/BRIEF.md
# Cascadable Fall-Through FIFO

This block is a first-in first-out store built as a chain of stages. Each stage holds one word and a valid bit. A word written at the input side moves one stage per clock toward the output, as long as the stage ahead of it is empty. A word taken from the output leaves an empty slot, and that slot moves one stage per clock back toward the input. Because of this, both flags react with a delay set by the depth. The default build is 64 stages of 4 bits.

The writer presents a word together with a shift-in strobe. The word is taken on a rising clock edge only while the input-ready flag is high. The reader takes the word on the output bus with a shift-out strobe. A word is removed on a rising clock edge only while the output-ready flag is high. After the store empties, the output bus keeps showing the last word removed.

Two copies form a deeper FIFO with no extra logic. The upstream copy's output-ready flag drives the downstream copy's shift-in strobe. The downstream copy's input-ready flag drives the upstream copy's shift-out strobe. The upstream output bus feeds the downstream input bus. An asynchronous active-high master reset empties every stage.

Top module: `cascade_fifo`

## Requirements
- R1: The store holds up to DEPTH words (64 by default) of WIDTH bits (4 by default). Words leave in the same order they were accepted. A stage never takes a new word while it still holds one.
- R2: `in_rdy` is low while the input stage holds a word. It stays low while the store is full. A `shift_in` strobe given while `in_rdy` is low changes nothing in the store.
- R3: `out_rdy` is high exactly when the output stage holds a word. A `shift_out` strobe given while `out_rdy` is low removes nothing.
- R4: While `out_rdy` stays low, `dout` holds its value. After the store runs empty, `dout` keeps showing the last word removed.
- R5: Take a word into an empty store on clock edge E0. `out_rdy` rises on edge E(DEPTH-1), so the word passes through DEPTH-1 more edges. On that same edge `dout` shows the word.
- R6: Start from a full store with `shift_in` low and remove a word on edge P0. The freed slot reaches the input stage, and `in_rdy` rises, on edge P(DEPTH-1).
- R7: Raising `mrst` at once, and with no clock edge needed, empties every stage. It also drives `out_rdy` low, `in_rdy` high and `dout` to zero.
- R8: In a cascaded pair, the downstream copy fills first. After 65 words have been accepted and the pair has settled, three things hold. The downstream copy is full with its `in_rdy` low. The upstream copy shows the 65th word on `dout` with `out_rdy` high. After 128 words both copies are full.
- R9: Start from a full cascaded pair and remove two words. Then hold the pair's `shift_in` high. The pair accepts exactly two more words, one for each slot that travels up to the upstream input stage.
- R10: A word is accepted only on an edge where `shift_in` and `in_rdy` are both high. A word is removed only on an edge where `shift_out` and `out_rdy` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all stage moves happen on its rising edge |
| mrst | input | 1 | Asynchronous active-high master reset; empties the store |
| shift_in | input | 1 | Write strobe; takes `din` on an edge while `in_rdy` is high |
| din | input | WIDTH | Word to be written |
| in_rdy | output | 1 | High when the input stage is empty and can take a word |
| shift_out | input | 1 | Read strobe; removes the output word on an edge while `out_rdy` is high |
| dout | output | WIDTH | Word in the output stage, or the last word removed |
| out_rdy | output | 1 | High when the output stage holds a valid word |

## Verification
Some rules are checked by assertions on every clock edge. A stage never takes a word while it is occupied. A removal always finds a word. A blocked input stage keeps its word unchanged. The input flag rises only after the stage behind it was empty. The output bus stays still while the output flag is low.

Other behaviour can only be shown by the bench scenarios. These include end-to-end ordering and the exact DEPTH-1 edge delays for a word falling through and for a slot bubbling up. They also include the 65-word and 128-word states of a cascaded pair and the two-word refill after two words are removed from a full pair. The bench also shows that extra strobes at full or empty leave the contents intact.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;

   // Smallest chain that still has a distinct input and output stage
   localparam int unsigned CFIFO_MIN_DEPTH = 2;
   localparam int unsigned CFIFO_MIN_WIDTH = 1;

   // Edges a word needs, after the accepting edge, to reach the last stage
   function automatic int unsigned cfifo_ripple_edges(input int unsigned depth);
      return depth - 1;
   endfunction

endpackage

// File: rtl/cfifo_cell.sv
module cfifo_cell #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         mrst,
   input  logic [W-1:0] src_data,
   input  logic         fill,
   input  logic         leave,
   output logic         valid,
   output logic [W-1:0] data
);

   always_ff @(posedge clk or posedge mrst) begin
      if (mrst) begin
         valid <= 1'b0;
         data  <= '0;
      end else if (fill) begin
         valid <= 1'b1;
         data  <= src_data;
      end else if (leave) begin
         valid <= 1'b0;
      end
   end

   AST_FILL_INTO_EMPTY: assert property (@(posedge clk) disable iff (mrst)
      fill |-> !valid);   // R1
   AST_LEAVE_OCCUPIED: assert property (@(posedge clk) disable iff (mrst)
      leave |-> valid);   // R10

endmodule

// File: rtl/cfifo_chain.sv
module cfifo_chain #(
   parameter int unsigned W = 4,
   parameter int unsigned D = 64
) (
   input  logic         clk,
   input  logic         mrst,
   input  logic [W-1:0] in_data,
   input  logic         in_take,
   input  logic         out_take,
   output logic         head_vld,
   output logic         pre_tail_vld,
   output logic         tail_vld,
   output logic [W-1:0] tail_data
);

   logic [D-1:0] vld;
   logic [D-1:0] fill;
   logic [D-1:0] leave;
   logic [W-1:0] dat [D];

   for (genvar i = 0; i < D; i++) begin : g_stage
      logic [W-1:0] src;

      if (i == 0) begin : g_head
         assign fill[i] = in_take;
         assign src     = in_data;
      end else begin : g_body
         // a word steps forward only into a slot that is already empty
         assign fill[i] = vld[i-1] & ~vld[i];
         assign src     = dat[i-1];
      end

      if (i == D - 1) begin : g_tail
         assign leave[i] = out_take;
      end else begin : g_pass
         assign leave[i] = fill[i+1];
      end

      cfifo_cell #(.W(W)) u_cell (
         .clk      (clk),
         .mrst     (mrst),
         .src_data (src),
         .fill     (fill[i]),
         .leave    (leave[i]),
         .valid    (vld[i]),
         .data     (dat[i])
      );
   end

   assign head_vld     = vld[0];
   assign pre_tail_vld = vld[D-2];
   assign tail_vld     = vld[D-1];
   assign tail_data    = dat[D-1];

   AST_HEAD_BLOCKED: assert property (@(posedge clk) disable iff (mrst)
      (vld[0] && vld[1]) |=> (vld[0] && $stable(dat[0])));   // R2
   AST_SLOT_FROM_NEXT: assert property (@(posedge clk) disable iff (mrst)
      $fell(vld[0]) |-> $past(!vld[1]));   // R6

endmodule

// File: rtl/cascade_fifo.sv
module cascade_fifo
   import cfifo_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned DEPTH = 64
) (
   input  logic             clk,
   input  logic             mrst,
   input  logic             shift_in,
   input  logic [WIDTH-1:0] din,
   output logic             in_rdy,
   input  logic             shift_out,
   output logic [WIDTH-1:0] dout,
   output logic             out_rdy
);

   localparam int unsigned RIPPLE = cfifo_ripple_edges(DEPTH);

   if (DEPTH < CFIFO_MIN_DEPTH) begin : g_bad_depth
      $error("cascade_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < CFIFO_MIN_WIDTH) begin : g_bad_width
      $error("cascade_fifo: WIDTH must be at least 1");
   end
   if (RIPPLE + 1 != DEPTH) begin : g_bad_ripple
      $error("cascade_fifo: ripple length mismatch");
   end

   logic head_vld;
   logic pre_tail_vld;
   logic tail_vld;
   logic in_take;
   logic out_take;

   assign in_take  = shift_in  & ~head_vld;
   assign out_take = shift_out &  tail_vld;

   cfifo_chain #(.W(WIDTH), .D(DEPTH)) u_chain (
      .clk          (clk),
      .mrst         (mrst),
      .in_data      (din),
      .in_take      (in_take),
      .out_take     (out_take),
      .head_vld     (head_vld),
      .pre_tail_vld (pre_tail_vld),
      .tail_vld     (tail_vld),
      .tail_data    (dout)
   );

   assign in_rdy  = ~head_vld;
   assign out_rdy = tail_vld;

   AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (mrst)
      (shift_out && !out_rdy && !pre_tail_vld) |=> !out_rdy);   // R3
   AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (mrst)
      !out_rdy |=> (out_rdy || $stable(dout)));   // R4

endmodule

// File: tb/tb_cascade_fifo.sv
`timescale 1ns/1ps
module tb_cascade_fifo;

   localparam int W = 4;
   localparam int D = 64;
   localparam logic [7:0] VEC [16] = '{
      8'h33, 8'hCC, 8'h00, 8'hFF, 8'h11, 8'hEE, 8'h55, 8'hAA,
      8'h77, 8'h88, 8'h22, 8'hDD, 8'h99, 8'h66, 8'h44, 8'hBB };

   logic clk = 1'b0;
   logic mrst = 1'b1;
   always #2.5 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;

   // single instance
   logic si = 0, so = 0;
   logic [W-1:0] din = '0, q;
   logic dir, dor;
   cascade_fifo #(.WIDTH(W), .DEPTH(D)) dut (
      .clk(clk), .mrst(mrst), .shift_in(si), .din(din), .in_rdy(dir),
      .shift_out(so), .dout(q), .out_rdy(dor));

   // cascaded pair: ca upstream, cb downstream
   logic ca_si = 0, cb_so = 0;
   logic [W-1:0] ca_din = '0, ca_q, cb_q;
   logic ca_dir, ca_dor, cb_dir, cb_dor;
   cascade_fifo #(.WIDTH(W), .DEPTH(D)) ca (
      .clk(clk), .mrst(mrst), .shift_in(ca_si), .din(ca_din), .in_rdy(ca_dir),
      .shift_out(cb_dir), .dout(ca_q), .out_rdy(ca_dor));
   cascade_fifo #(.WIDTH(W), .DEPTH(D)) cb (
      .clk(clk), .mrst(mrst), .shift_in(ca_dor), .din(ca_q), .in_rdy(cb_dir),
      .shift_out(cb_so), .dout(cb_q), .out_rdy(cb_dor));

   logic [W-1:0] mdl [$];
   logic [W-1:0] cmdl [$];

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push1(input logic [W-1:0] w);
      for (int g = 0; g < 1000 && !dir; g++) @(negedge clk);
      si = 1; din = w; mdl.push_back(w);
      @(negedge clk);
      si = 0;
   endtask

   task automatic pop1(input string req);
      logic [W-1:0] e;
      for (int g = 0; g < 1000 && !dor; g++) @(negedge clk);
      e = mdl.pop_front();
      chk(req, q, e);
      so = 1;
      @(negedge clk);
      so = 0;
   endtask

   task automatic cpush(input logic [W-1:0] w);
      for (int g = 0; g < 1000 && !ca_dir; g++) @(negedge clk);
      ca_si = 1; ca_din = w; cmdl.push_back(w);
      @(negedge clk);
      ca_si = 0;
   endtask

   task automatic cpop(input string req);
      logic [W-1:0] e;
      for (int g = 0; g < 1000 && !cb_dor; g++) @(negedge clk);
      e = cmdl.pop_front();
      chk(req, cb_q, e);
      cb_so = 1;
      @(negedge clk);
      cb_so = 0;
   endtask

   function automatic logic [W-1:0] cw(input int i);
      return W'((i * 7 + 3) % 16);
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      int cnt;
      int acc;
      logic [W-1:0] last;
      #12;
      // R7: reset state
      chk("R7 in_rdy", dir, 1);
      chk("R7 out_rdy", dor, 0);
      chk("R7 dout", q, 0);
      mrst = 0;
      @(negedge clk);

      // R5: fall-through latency
      si = 1; din = 4'h9; mdl.push_back(4'h9);
      @(negedge clk);
      si = 0;
      cnt = 0;
      while (!dor && cnt < 500) begin @(negedge clk); cnt++; end
      chk("R5 fall edges", cnt, D - 1);
      chk("R5 dout", q, 9);
      pop1("R10 pop");
      chk("R3 empty", dor, 0);
      // R3/R4: strobes on empty store
      so = 1;
      repeat (5) @(negedge clk);
      so = 0;
      chk("R3 no pop", dor, 0);
      chk("R4 last word", q, 9);

      // R1: table of vectors, pushed then drained in order
      for (int i = 0; i < 16; i++) push1(VEC[i][7:4]);
      for (int i = 0; i < 16; i++) begin
         for (int g = 0; g < 1000 && !dor; g++) @(negedge clk);
         chk("R1 order vector", q, VEC[i][3:0]);
         void'(mdl.pop_front());
         so = 1; @(negedge clk); so = 0;
      end
      chk("R4 hold after drain", q, VEC[15][3:0]);

      // R2: fill to capacity, extra strobes ignored
      for (int i = 0; i < D; i++) push1(W'((i ^ 5) % 16));
      repeat (200) @(negedge clk);
      chk("R2 full in_rdy", dir, 0);
      chk("R1 full out_rdy", dor, 1);
      si = 1; din = 4'hF;
      repeat (10) @(negedge clk);
      si = 0;
      chk("R2 still full", dir, 0);
      // R6: bubble-up latency
      pop1("R1 first out");
      cnt = 0;
      while (!dir && cnt < 500) begin @(negedge clk); cnt++; end
      chk("R6 bubble edges", cnt, D - 1);
      for (int i = 1; i < D; i++) pop1("R2 contents after full");
      repeat (5) @(negedge clk);
      chk("R2 no extra word", dor, 0);

      // R7: async reset mid-stream
      push1(4'h3); push1(4'h6);
      repeat (80) @(negedge clk);
      #1 mrst = 1;
      #0.5;
      chk("R7 async in_rdy", dir, 1);
      chk("R7 async out_rdy", dor, 0);
      chk("R7 async dout", q, 0);
      mdl.delete();
      @(negedge clk);
      mrst = 0;
      @(negedge clk);

      // R8: cascaded pair
      for (int i = 0; i < 65; i++) cpush(cw(i));
      repeat (400) @(negedge clk);
      chk("R8 down full", cb_dir, 0);
      chk("R8 up out_rdy", ca_dor, 1);
      chk("R8 65th word", ca_q, cw(64));
      for (int i = 65; i < 128; i++) cpush(cw(i));
      repeat (400) @(negedge clk);
      chk("R8 up full", ca_dir, 0);
      chk("R8 down out_rdy", cb_dor, 1);

      // R9: two removals, exactly two refills
      cpop("R9 pop a");
      cpop("R9 pop b");
      acc = 0;
      ca_si = 1; ca_din = 4'hA;
      repeat (600) begin
         if (ca_dir) begin acc++; cmdl.push_back(4'hA); end
         @(negedge clk);
      end
      ca_si = 0;
      chk("R9 refill count", acc, 2);
      for (int i = 0; i < 128; i++) cpop("R8 pair order");
      repeat (300) @(negedge clk);
      chk("R8 pair empty", cb_dor, 0);
      last = 4'hA;
      chk("R4 pair last word", cb_q, last);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule